// File: doc/BRIEF.md
# Page-Mode Byte-Wide Memory Bus Controller

This block lets a synchronous host read and write an asynchronous, byte-wide nonvolatile memory with a 17-bit address and an 8-bit bidirectional data bus. The host posts a request on a valid/ready port. A request carries a direction, a start address and a burst length of one to eight bytes. The controller then drives the active-low chip-enable, write-enable and output-enable strobes, the address lines and the tri-state data lines. Each strobe phase lasts a parameterised number of clock cycles.

The memory takes the whole address when chip enable falls. After that it only follows the low three address bits, which select a column within an 8-byte page. A burst therefore runs as one chip-enable-low period per page, and only the column bits step from beat to beat. When a burst crosses a page boundary, the controller closes chip enable, waits out the precharge time and opens a new period with the new upper address.

An active-low lockout input stops all new memory activity while the supply is unsafe. If lockout arrives during a burst, the strobe pulse already in progress finishes in full, the remaining beats are dropped, and the request ends with an error response.

Top module: `pmem_ctrl`

## Requirements
- R1: After reset, all three strobes are high and the controller does not drive the data lines. `rd_valid`, `wd_pop` and `done` are low, and `req_ready` equals `lvl_n`.
- R2: Upper address bits [16:3] stay constant for as long as chip enable is low. The full address is stable on the cycle before chip enable falls.
- R3: A burst whose beats all fall inside one 8-byte page uses exactly one chip-enable-low period. Each beat steps address bits [2:0] by one.
- R4: A burst that crosses a page boundary produces one chip-enable-low period per page touched. The address wraps from 0x1FFFF to 0x00000.
- R5: Each write beat is one write-enable pulse of exactly T_PULSE cycles, and output enable stays high during it. The byte taken from `wd_data` ends up in the memory at that beat's address.
- R6: Each read beat is one output-enable pulse of exactly T_PULSE cycles. The bus is sampled on the last cycle of the pulse, and the byte is returned with a one-cycle `rd_valid` pulse, in address order.
- R7: The controller never drives the data lines while output enable is low.
- R8: Between any two chip-enable-low periods, chip enable stays high for at least T_PRE cycles.
- R9: While `lvl_n` is low, `req_ready` is low and chip enable does not fall.
- R10: If `lvl_n` goes low during a burst, the current strobe pulse completes at full width and no further beat starts. The request then ends with `done` asserted and `done_err` set to 1.
- R11: Every accepted request yields exactly one `done` pulse. `done_err` is 0 when all beats ran.
- R12: `req_len` holds the beat count minus one. A request performs exactly `req_len`+1 beats, and on writes `wd_pop` pulses once per beat, on the cycle after that beat's byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_n | input | 1 | Supply-safe flag, low = lockout |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 17 | Start byte address |
| req_len | input | 3 | Beats minus one |
| wd_data | input | 8 | Next write byte, held by host until popped |
| wd_pop | output | 1 | Write byte was taken on the previous edge |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request finished pulse |
| done_err | output | 1 | Request ended early by lockout |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq | inout | 8 | Memory data lines |

## Verification
A wrong beat counter or a wrong page-crossing decision shows up at the ports within one burst. It appears as a missing or extra chip-enable-low period, a wrong `rd_valid` or `wd_pop` count, or a byte landing at the wrong column. A phase timer that is off by one shows on the very next strobe as a pulse of the wrong width or a short precharge gap. A missed lockout check shows within one beat time, as a strobe pulse after `lvl_n` fell or a `done_err` that stays 0. Every start column and every burst length is swept, so each position of the page boundary is crossed, and the read-back after each write compares every byte with an arithmetic pattern.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    localparam int MEM_AW   = 17;
    localparam int MEM_DW   = 8;
    localparam int BURST_LW = 3;
    localparam int PAGE_CW  = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_COL,
        PH_STROBE,
        PH_HOLD,
        PH_PRE
    } phase_e;

    typedef struct packed {
        logic wr;
        logic more;
        logic err;
    } job_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pmem_timer.sv
module pmem_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pmem_beat.sv
module pmem_beat #(
    parameter int AW = 17,
    parameter int LW = 3,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          col_end
);
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_len;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign addr    = addr_q;
    assign last    = (rem_q == '0);
    assign col_end = (addr_q[CW-1:0] == {CW{1'b1}});
endmodule

// File: rtl/pmem_ctrl.sv
module pmem_ctrl
    import pmem_pkg::*;
#(
    parameter int T_SETUP = 1,
    parameter int T_PULSE = 2,
    parameter int T_HOLD  = 1,
    parameter int T_PRE   = 2,
    parameter int AW      = MEM_AW,
    parameter int DW      = MEM_DW,
    parameter int LW      = BURST_LW,
    parameter int CW      = PAGE_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [DW-1:0] wd_data,
    output logic          wd_pop,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          done_err,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    inout  wire  [DW-1:0] mem_dq
);
    localparam int TMAX  = max_of4(T_SETUP, T_PULSE, T_HOLD, T_PRE);
    localparam int CNT_W = $clog2(TMAX + 1);
    localparam logic [CNT_W-1:0] V_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] V_PULSE = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] V_HOLD  = CNT_W'(T_HOLD - 1);
    localparam logic [CNT_W-1:0] V_PRE   = CNT_W'(T_PRE - 1);

    phase_e           ph_q, ph_d;
    job_t             job_q;
    logic             t_load, t_zero;
    logic [CNT_W-1:0] t_val;
    logic             accept, step, finish, abort, split;
    logic             last, col_end;
    logic [DW-1:0]    wdat_q;
    logic             pop_q, rv_q, done_q, derr_q;
    logic [DW-1:0]    rdat_q;
    logic             dq_oe;

    pmem_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    pmem_beat #(.AW(AW), .LW(LW), .CW(CW)) i_beat (
        .clk(clk), .rst(rst), .load(accept), .load_addr(req_addr), .load_len(req_len),
        .step(step), .addr(mem_addr), .last(last), .col_end(col_end)
    );

    assign req_ready = (ph_q == PH_IDLE) && lvl_n;

    always_comb begin
        ph_d   = ph_q;
        t_load = 1'b0;
        t_val  = '0;
        accept = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        abort  = 1'b0;
        split  = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (req_valid && req_ready) begin
                accept = 1'b1;
                ph_d = PH_SETUP; t_load = 1'b1; t_val = V_SETUP;
            end
            PH_SETUP: if (t_zero) begin
                if (!lvl_n) begin
                    ph_d = PH_IDLE; finish = 1'b1; abort = 1'b1;
                end else begin
                    ph_d = PH_COL; t_load = 1'b1; t_val = V_SETUP;
                end
            end
            PH_COL: if (t_zero) begin
                ph_d = PH_STROBE; t_load = 1'b1; t_val = V_PULSE;
            end
            PH_STROBE: if (t_zero) begin
                ph_d = PH_HOLD; t_load = 1'b1; t_val = V_HOLD;
            end
            PH_HOLD: if (t_zero) begin
                if (last) begin
                    ph_d = PH_PRE; t_load = 1'b1; t_val = V_PRE;
                end else if (!lvl_n) begin
                    ph_d = PH_PRE; t_load = 1'b1; t_val = V_PRE; abort = 1'b1;
                end else if (col_end) begin
                    ph_d = PH_PRE; t_load = 1'b1; t_val = V_PRE; split = 1'b1;
                end else begin
                    step = 1'b1;
                    ph_d = PH_COL; t_load = 1'b1; t_val = V_SETUP;
                end
            end
            PH_PRE: if (t_zero) begin
                if (job_q.more && lvl_n) begin
                    step = 1'b1;
                    ph_d = PH_SETUP; t_load = 1'b1; t_val = V_SETUP;
                end else begin
                    ph_d = PH_IDLE; finish = 1'b1; abort = job_q.more;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            job_q  <= '0;
            wdat_q <= '0;
            pop_q  <= 1'b0;
            rv_q   <= 1'b0;
            rdat_q <= '0;
            done_q <= 1'b0;
            derr_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            pop_q  <= 1'b0;
            rv_q   <= 1'b0;
            done_q <= finish;
            derr_q <= finish && (job_q.err || abort);
            if (accept) begin
                job_q.wr   <= req_write;
                job_q.more <= 1'b0;
                job_q.err  <= 1'b0;
            end else begin
                if (split) job_q.more <= 1'b1;
                else if (ph_q == PH_PRE && t_zero) job_q.more <= 1'b0;
                if (abort) job_q.err <= 1'b1;
            end
            if (ph_d == PH_COL && ph_q != PH_COL && job_q.wr) begin
                wdat_q <= wd_data;
                pop_q  <= 1'b1;
            end
            if (ph_q == PH_STROBE && t_zero && !job_q.wr) begin
                rdat_q <= mem_dq;
                rv_q   <= 1'b1;
            end
        end
    end

    assign mem_ce_n = !(ph_q == PH_COL || ph_q == PH_STROBE || ph_q == PH_HOLD);
    assign mem_we_n = !(ph_q == PH_STROBE && job_q.wr);
    assign mem_oe_n = !(ph_q == PH_STROBE && !job_q.wr);
    assign dq_oe    = job_q.wr && !mem_ce_n;
    assign mem_dq   = dq_oe ? wdat_q : 'z;

    assign wd_pop   = pop_q;
    assign rd_valid = rv_q;
    assign rd_data  = rdat_q;
    assign done     = done_q;
    assign done_err = derr_q;

    // Checks: chip-enable high run length, saturating at T_PRE
    logic [CNT_W:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (rst)                                  hi_run_q <= (CNT_W+1)'(T_PRE);
        else if (!mem_ce_n)                       hi_run_q <= '0;
        else if (hi_run_q < (CNT_W+1)'(T_PRE))    hi_run_q <= hi_run_q + 1'b1;
    end

    p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> hi_run_q >= (CNT_W+1)'(T_PRE));

    p_upper_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr[AW-1:CW]));

    p_addr_setup_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> $stable(mem_addr));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !dq_oe);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n));

    p_lock_start_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> $past(lvl_n));

    p_lock_ready_r9: assert property (@(posedge clk) disable iff (rst)
        !lvl_n |-> !req_ready);

    p_done_once_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);
endmodule

// File: tb/test_pmem_ctrl.sv
module test_pmem_ctrl;
    localparam int T_PULSE = 2;
    localparam int T_PRE   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lvl_n = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [7:0]  wd_data = '0;
    logic        req_ready, wd_pop, rd_valid, done, done_err;
    logic [7:0]  rd_data;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [16:0] mem_addr;
    wire  [7:0]  mem_dq;

    always #10 clk = ~clk;

    pmem_ctrl #(.T_SETUP(1), .T_PULSE(T_PULSE), .T_HOLD(1), .T_PRE(T_PRE)) i_pmem_ctrl (
        .clk(clk), .rst(rst), .lvl_n(lvl_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .wd_data(wd_data),
        .wd_pop(wd_pop), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .done_err(done_err), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] idx(input logic [16:0] a);
        return a[10:0];
    endfunction

    // Memory model
    logic [7:0]  mdl    [0:2047];
    logic [7:0]  shadow [0:2047];
    logic [13:0] hi_lat = '0;
    logic [2:0]  col_lat = '0;
    logic [7:0]  drv;
    int ce_falls = 0, we_pulses = 0;

    always @(negedge mem_ce_n) if (!rst) begin
        hi_lat  = mem_addr[16:3];
        col_lat = mem_addr[2:0];
        ce_falls++;
    end
    always @(negedge mem_we_n) if (!rst && !mem_ce_n) col_lat = mem_addr[2:0];
    always @(posedge mem_we_n) if (!rst && !mem_ce_n) begin
        mdl[idx({hi_lat, col_lat})] = mem_dq;
        we_pulses++;
    end
    always_comb drv = mdl[idx({hi_lat, mem_addr[2:0]})];
    assign mem_dq = (!mem_ce_n && !mem_oe_n) ? drv : 8'bz;

    // Port monitors
    int we_run = 0, oe_run = 0, ce_hi = 0;
    bit ce_seen_low = 0;
    always @(negedge clk) if (!rst) begin
        if (!mem_ce_n) begin
            if (mem_addr[16:3] != hi_lat) chk(0, "R2 upper address moved", int'(mem_addr[16:3]), int'(hi_lat));
            if (ce_seen_low && ce_hi > 0) chk(ce_hi >= T_PRE, "R8 precharge", ce_hi, T_PRE);
            ce_hi = 0;
            ce_seen_low = 1;
        end else ce_hi++;
        if (!mem_we_n) we_run++;
        else if (we_run > 0) begin chk(we_run == T_PULSE, "R5 write pulse width", we_run, T_PULSE); we_run = 0; end
        if (!mem_oe_n) begin
            oe_run++;
            if (!mem_we_n) chk(0, "R7 strobes overlap", 1, 0);
        end else if (oe_run > 0) begin chk(oe_run == T_PULSE, "R6 read pulse width", oe_run, T_PULSE); oe_run = 0; end
    end

    // Host side collectors
    logic [7:0] wbuf [0:7];
    logic [7:0] rd_buf [0:7];
    int rd_cnt = 0, pop_cnt = 0, done_cnt = 0, wd_idx = 0;
    logic last_err = 0;
    always @(negedge clk) if (!rst) begin
        if (rd_valid) begin
            if (rd_cnt < 8) rd_buf[rd_cnt] = rd_data;
            rd_cnt++;
        end
        if (done) begin done_cnt++; last_err = done_err; end
        if (wd_pop) begin
            pop_cnt++;
            wd_idx++;
            wd_data = wbuf[wd_idx[2:0]];
        end
    end

    task automatic prep(input int n, input int seed);
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(seed * 13 + k * 29 + 5);
        wd_idx = 0; wd_data = wbuf[0];
        rd_cnt = 0; pop_cnt = 0; done_cnt = 0;
        ce_falls = 0; we_pulses = 0;
        if (n < 0) wd_idx = 0;
    endtask

    task automatic issue(input bit wr, input logic [16:0] a, input int n);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_len = 3'(n - 1);
        for (int i = 0; i < 1000; i++) begin
            if (req_ready) begin @(negedge clk); req_valid = 0; break; end
            @(negedge clk);
        end
        req_valid = 0;
    endtask

    task automatic wait_done;
        for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
        chk(done_cnt == 1, "R11 done count", done_cnt, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input bit wr, input logic [16:0] a, input int n, input int seed);
        int pages;
        logic [16:0] ak;
        prep(n, seed);
        issue(wr, a, n);
        wait_done();
        pages = ((int'(a[2:0]) + n - 1) / 8) + 1;
        chk(ce_falls == pages, pages > 1 ? "R4 pages" : "R3 one ce period", ce_falls, pages);
        chk(last_err == 0, "R11 error flag", int'(last_err), 0);
        if (wr) begin
            chk(pop_cnt == n, "R12 pops", pop_cnt, n);
            chk(we_pulses == n, "R5 write pulses", we_pulses, n);
            for (int k = 0; k < n; k++) begin
                ak = a + 17'(k);
                shadow[idx(ak)] = wbuf[k];
                chk(mdl[idx(ak)] == wbuf[k], "R5 stored byte", int'(mdl[idx(ak)]), int'(wbuf[k]));
            end
        end else begin
            chk(rd_cnt == n, "R12 read beats", rd_cnt, n);
            for (int k = 0; k < n && k < 8; k++) begin
                ak = a + 17'(k);
                chk(rd_buf[k] == shadow[idx(ak)], "R6 read byte", int'(rd_buf[k]), int'(shadow[idx(ak)]));
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mdl[i] = 8'(i * 37 + 11);
            shadow[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        chk(!rd_valid && !wd_pop && !done, "R1 pulses low", int'({rd_valid, wd_pop, done}), 0);
        chk(req_ready == 1, "R1 ready", int'(req_ready), 1);
        chk(mem_dq === 8'bz, "R1 bus released", int'(mem_dq), 0);

        // Sweep: every start column and length, write then read back
        for (int off = 0; off < 8; off++)
            for (int n = 1; n <= 8; n++) begin
                run(1, 17'h00A40 + 17'(off), n, off * 8 + n);
                run(0, 17'h00A40 + 17'(off), n, 0);
            end
        // R4 address wrap at top of space
        run(1, 17'h1FFFE, 4, 99);
        run(0, 17'h1FFFE, 4, 0);

        // R9 lockout at idle
        @(negedge clk) lvl_n = 0;
        @(negedge clk);
        chk(req_ready == 0, "R9 ready under lockout", int'(req_ready), 0);
        prep(1, 0);
        req_valid = 1; req_write = 0; req_addr = 17'h00300; req_len = 3'd3;
        repeat (20) @(negedge clk);
        chk(ce_falls == 0, "R9 no access under lockout", ce_falls, 0);
        chk(done_cnt == 0, "R9 no response under lockout", done_cnt, 0);
        req_valid = 0;
        @(negedge clk) lvl_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R9 ready after lockout", int'(req_ready), 1);

        // R10 lockout during read burst after second byte
        prep(8, 0);
        issue(0, 17'h00200, 8);
        for (int i = 0, seen = 0; i < 400 && seen < 2; i++) begin
            if (rd_valid) seen++;
            if (seen == 2) lvl_n = 0;
            else @(negedge clk);
        end
        wait_done();
        chk(rd_cnt == 2, "R10 read beats before abort", rd_cnt, 2);
        chk(last_err == 1, "R10 error response", int'(last_err), 1);
        chk(ce_falls == 1, "R10 single ce period", ce_falls, 1);
        lvl_n = 1;
        repeat (3) @(negedge clk);

        // R10 lockout during a write pulse
        prep(4, 77);
        issue(1, 17'h00100, 4);
        for (int i = 0; i < 400 && mem_we_n; i++) @(negedge clk);
        lvl_n = 0;
        wait_done();
        chk(we_pulses == 1, "R10 write pulses", we_pulses, 1);
        chk(pop_cnt == 1, "R10 pops", pop_cnt, 1);
        chk(last_err == 1, "R10 error response", int'(last_err), 1);
        chk(mdl[idx(17'h00100)] == wbuf[0], "R10 pulse completed", int'(mdl[idx(17'h00100)]), int'(wbuf[0]));
        chk(mdl[idx(17'h00101)] == shadow[idx(17'h00101)], "R10 next byte untouched",
            int'(mdl[idx(17'h00101)]), int'(shadow[idx(17'h00101)]));
        shadow[idx(17'h00100)] = wbuf[0];
        @(negedge clk) lvl_n = 1;
        repeat (3) @(negedge clk);
        run(0, 17'h000FE, 6, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule